// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block collects requests from 32 peripheral interrupt lines and decides which one, if any, the CPU should service next. Each line has an enable bit, a pending bit and a 2-bit urgency level. Software changes these bits over a simple register bus. Enable and pending state have separate "set" and "clear" registers, and in each one only the bits written as 1 act. This means software never needs a read-modify-write sequence to change one line.

Every cycle the controller looks at the lines that are both pending and enabled. It picks the most urgent one: the lowest level value wins, and on a tie the lowest line index wins. It offers that line to the CPU as an exception number equal to 16 plus the line index. The offer is made only when the global mask input is low and, if a handler is already running, only when the candidate is strictly more urgent than that handler.

When the CPU accepts an offer, the controller clears the line's pending bit and pushes the line's level onto a stack of active handlers. A return pulse from the CPU pops that stack. Together these two steps let handlers nest by urgency.

Top module: `irq_nest_ctrl`

## Requirements
- R1: A write to offset 0x100 sets each enable bit n whose data bit n is 1. Bits written as 0 keep their value. A read of 0x100 or 0x180 returns the enable vector, with bit n belonging to line n.
- R2: A write to offset 0x180 clears each enable bit n whose data bit n is 1. Bits written as 0 keep their value.
- R3: A write to offset 0x200 makes each line n pending whose data bit n is 1. A read of 0x200 or 0x280 returns the pending vector.
- R4: A write to offset 0x280 clears each pending bit n whose data bit n is 1, unless that line's input is high in the same cycle.
- R5: A line input that is high at a clock edge sets that line's pending bit. This happens whatever the enable bits or the mask input hold.
- R6: Only lines that are both pending and enabled take part in selection. The line with the lowest level value is chosen, and a tie goes to the lowest index. cpu_excnum equals 16 plus the chosen index, so it is never below 16.
- R7: While mask_in is 1, cpu_req stays 0. Pending bits keep collecting requests during this time.
- R8: With no active handler, any eligible line raises cpu_req. With handlers active, cpu_req rises only if the chosen level value is strictly smaller than active_prio. The nesting depth never exceeds 4.
- R9: A cycle with cpu_ack and cpu_req both high clears the chosen line's pending bit. It also pushes that line's level, so active_depth goes up by one and active_prio becomes the level. A cpu_ack while cpu_req is low has no effect.
- R10: A cpu_ret pulse pops the active stack, so active_depth goes down by one and active_prio shows the new top. A cpu_ret with an empty stack has no effect. active_prio reads 0 when the stack is empty.
- R11: Line 4k+j takes its level from bits [8j+1:8j] of the word at offset 0x400+4k, for k from 0 to 7. The word reads back with all other bits as 0.
- R12: After reset, all enable bits, pending bits and levels are 0, active_depth is 0, and cpu_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_lines | input | 32 | Peripheral request lines, level sensitive |
| mask_in | input | 1 | Global mask; 1 blocks delivery |
| cpu_req | output | 1 | A line is offered to the CPU |
| cpu_excnum | output | 6 | Exception number of the offered line |
| cpu_ack | input | 1 | CPU accepts the offered line |
| cpu_ret | input | 1 | CPU returns from the current handler |
| active_depth | output | 3 | Number of nested active handlers |
| active_prio | output | 2 | Level of the innermost active handler |

## Verification
The selection logic is swept over every ordered pair of pending lines, including the pairs where both entries name the same line. This runs with a fixed scattered level map and with every sixth line disabled. The sweep separates the level comparison, the index tie-break and enable gating, and it also covers the case where neither line is eligible. A scripted nesting sequence then uses one line at each level. It separates strict preemption from same-level blocking and checks that push and pop restore the right level. Separate patterns cover the mask input, level-sensitive line inputs, ignored acknowledge and return pulses, and the read-back of the level words.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
    localparam int unsigned LINE_COUNT = 32;
    localparam int unsigned LEVEL_BITS = 2;
    localparam int unsigned EXC_OFFSET = 16;
    localparam int unsigned ADDR_BITS  = 12;
    localparam int unsigned DATA_BITS  = 32;
    localparam int unsigned OFS_EN_SET = 'h100;
    localparam int unsigned OFS_EN_CLR = 'h180;
    localparam int unsigned OFS_PD_SET = 'h200;
    localparam int unsigned OFS_PD_CLR = 'h280;
    localparam int unsigned OFS_LEVEL  = 'h400;
    localparam int unsigned LEVEL_LANES = 4;
endpackage

// File: rtl/irq_line_regs.sv
module irq_line_regs
    import irq_nest_pkg::*;
#(
    parameter int unsigned N  = LINE_COUNT,
    parameter int unsigned PW = LEVEL_BITS,
    parameter int unsigned AW = ADDR_BITS,
    parameter int unsigned DW = DATA_BITS,
    localparam int unsigned IW = $clog2(N),
    localparam int unsigned LANE_W = DW / LEVEL_LANES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N-1:0]  irq_lines,
    input  logic          ack_valid,
    input  logic [IW-1:0] ack_idx,
    output logic [N-1:0]  enable_vec,
    output logic [N-1:0]  pending_vec,
    output logic [N*PW-1:0] level_flat
);
    typedef struct packed {
        logic [N-1:0]    en;
        logic [N-1:0]    pend;
        logic [N*PW-1:0] lvl;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       wr_en;

    always_comb begin
        st_d  = st_q;
        wr_en = bus_sel & bus_wr;
        // enable set / clear
        if (wr_en && bus_addr == AW'(OFS_EN_SET)) st_d.en = st_d.en | bus_wdata[N-1:0];
        if (wr_en && bus_addr == AW'(OFS_EN_CLR)) st_d.en = st_d.en & ~bus_wdata[N-1:0];
        // pending: acknowledge clear, software set/clear, then hardware lines
        if (ack_valid) st_d.pend[ack_idx] = 1'b0;
        if (wr_en && bus_addr == AW'(OFS_PD_SET)) st_d.pend = st_d.pend | bus_wdata[N-1:0];
        if (wr_en && bus_addr == AW'(OFS_PD_CLR)) st_d.pend = st_d.pend & ~bus_wdata[N-1:0];
        st_d.pend = st_d.pend | irq_lines;
        // level words: four lines per word, one byte lane each
        for (int i = 0; i < N; i++) begin
            if (wr_en && bus_addr == AW'(OFS_LEVEL + 4 * (i / LEVEL_LANES))) begin
                st_d.lvl[i*PW +: PW] = bus_wdata[LANE_W*(i % LEVEL_LANES) +: PW];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == AW'(OFS_EN_SET) || bus_addr == AW'(OFS_EN_CLR)) begin
                bus_rdata[N-1:0] = st_q.en;
            end
            if (bus_addr == AW'(OFS_PD_SET) || bus_addr == AW'(OFS_PD_CLR)) begin
                bus_rdata[N-1:0] = st_q.pend;
            end
            for (int i = 0; i < N; i++) begin
                if (bus_addr == AW'(OFS_LEVEL + 4 * (i / LEVEL_LANES))) begin
                    bus_rdata[LANE_W*(i % LEVEL_LANES) +: PW] = st_q.lvl[i*PW +: PW];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable_vec  = st_q.en;
    assign pending_vec = st_q.pend;
    assign level_flat  = st_q.lvl;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_nest_pkg::*;
#(
    parameter int unsigned N  = LINE_COUNT,
    parameter int unsigned PW = LEVEL_BITS,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]    eligible,
    input  logic [N*PW-1:0] level_flat,
    output logic            found,
    output logic [IW-1:0]   win_idx,
    output logic [PW-1:0]   win_level
);
    // Strict less-than keeps the lower index on equal levels.
    always_comb begin
        found     = 1'b0;
        win_idx   = '0;
        win_level = '0;
        for (int i = 0; i < N; i++) begin
            if (eligible[i] && (!found || level_flat[i*PW +: PW] < win_level)) begin
                found     = 1'b1;
                win_idx   = IW'(i);
                win_level = level_flat[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack
    import irq_nest_pkg::*;
#(
    parameter int unsigned PW = LEVEL_BITS,
    localparam int unsigned DEPTH = 1 << PW,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] push_level,
    input  logic          pop,
    output logic [CW-1:0] depth,
    output logic [PW-1:0] top_level,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH*PW-1:0] slots;
        logic [CW-1:0]       cnt;
    } stk_state_t;

    stk_state_t st_d, st_q;
    logic [CW-1:0] after_pop;

    always_comb begin
        st_d      = st_q;
        after_pop = st_q.cnt;
        if (pop && st_q.cnt != '0) after_pop = st_q.cnt - 1'b1;
        st_d.cnt = after_pop;
        if (push && after_pop != CW'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == after_pop) st_d.slots[i*PW +: PW] = push_level;
            end
            st_d.cnt = after_pop + 1'b1;
        end
    end

    always_comb begin
        top_level = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i + 1) == st_q.cnt) top_level = st_q.slots[i*PW +: PW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign depth = st_q.cnt;
    assign empty = (st_q.cnt == '0);
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int unsigned N  = LINE_COUNT,
    parameter int unsigned PW = LEVEL_BITS,
    parameter int unsigned AW = ADDR_BITS,
    parameter int unsigned DW = DATA_BITS,
    localparam int unsigned IW = $clog2(N),
    localparam int unsigned EW = $clog2(EXC_OFFSET + N),
    localparam int unsigned CW = $clog2((1 << PW) + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N-1:0]  irq_lines,
    input  logic          mask_in,
    output logic          cpu_req,
    output logic [EW-1:0] cpu_excnum,
    input  logic          cpu_ack,
    input  logic          cpu_ret,
    output logic [CW-1:0] active_depth,
    output logic [PW-1:0] active_prio
);
    logic [N-1:0]    enable_vec, pending_vec;
    logic [N*PW-1:0] level_flat;
    logic            found;
    logic [IW-1:0]   win_idx;
    logic [PW-1:0]   win_prio;
    logic [PW-1:0]   top_level;
    logic            stk_empty;
    logic            preempt_ok;
    logic            take;

    irq_line_regs #(.N(N), .PW(PW), .AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_lines  (irq_lines),
        .ack_valid  (take),
        .ack_idx    (win_idx),
        .enable_vec (enable_vec),
        .pending_vec(pending_vec),
        .level_flat (level_flat)
    );

    irq_pick #(.N(N), .PW(PW)) u_pick (
        .eligible  (pending_vec & enable_vec),
        .level_flat(level_flat),
        .found     (found),
        .win_idx   (win_idx),
        .win_level (win_prio)
    );

    irq_active_stack #(.PW(PW)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .push_level(win_prio),
        .pop       (cpu_ret),
        .depth     (active_depth),
        .top_level (top_level),
        .empty     (stk_empty)
    );

    assign preempt_ok  = stk_empty || (win_prio < top_level);
    assign cpu_req     = found && !mask_in && preempt_ok;
    assign take        = cpu_req && cpu_ack;
    assign cpu_excnum  = EW'(EXC_OFFSET) + EW'(win_idx);
    assign active_prio = stk_empty ? '0 : top_level;
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk #(
    parameter int unsigned N  = 32,
    parameter int unsigned PW = 2,
    localparam int unsigned EW = $clog2(16 + N),
    localparam int unsigned CW = $clog2((1 << PW) + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mask_in,
    input logic          cpu_req,
    input logic          cpu_ack,
    input logic          cpu_ret,
    input logic [EW-1:0] cpu_excnum,
    input logic [CW-1:0] active_depth,
    input logic [PW-1:0] active_prio,
    input logic [PW-1:0] win_prio
);
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        mask_in |-> !cpu_req);

    a_r6_excnum_range: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (cpu_excnum >= EW'(16) && cpu_excnum < EW'(16 + N)));

    a_r8_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && active_depth != '0) |-> (win_prio < active_prio));

    a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        active_depth <= CW'(1 << PW));

    a_r9_ack_push: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ack && !cpu_ret) |=>
        (active_depth == $past(active_depth) + 1'b1 && active_prio == $past(win_prio)));

    a_r10_ret_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ret && !(cpu_req && cpu_ack) && active_depth != '0) |=>
        (active_depth == $past(active_depth) - 1'b1));

    a_r10_ret_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ret && !cpu_ack && active_depth == '0) |=> (active_depth == '0));
endmodule

bind irq_nest_ctrl irq_nest_chk #(.N(N), .PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_in     (mask_in),
    .cpu_req     (cpu_req),
    .cpu_ack     (cpu_ack),
    .cpu_ret     (cpu_ret),
    .cpu_excnum  (cpu_excnum),
    .active_depth(active_depth),
    .active_prio (active_prio),
    .win_prio    (win_prio)
);

// File: tb/test_irq_nest_ctrl.sv
module test_irq_nest_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] irq_lines = '0;
    logic        mask_in = 1'b0;
    logic        cpu_req;
    logic [5:0]  cpu_excnum;
    logic        cpu_ack = 1'b0, cpu_ret = 1'b0;
    logic [2:0]  active_depth;
    logic [1:0]  active_prio;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    irq_nest_ctrl i_irq_nest_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lines(irq_lines), .mask_in(mask_in), .cpu_req(cpu_req),
        .cpu_excnum(cpu_excnum), .cpu_ack(cpu_ack), .cpu_ret(cpu_ret),
        .active_depth(active_depth), .active_prio(active_prio)
    );

    localparam logic [11:0] EN_SET = 12'h100, EN_CLR = 12'h180;
    localparam logic [11:0] PD_SET = 12'h200, PD_CLR = 12'h280, LVL = 12'h400;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); cpu_ack = 1'b1;
        @(negedge clk); cpu_ack = 1'b0;
    endtask

    task automatic pulse_ret();
        @(negedge clk); cpu_ret = 1'b1;
        @(negedge clk); cpu_ret = 1'b0;
    endtask

    function automatic int lvl_of(input int n);
        return (n * 3 + n / 8) % 4;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d, en_pat, exp_en, word;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rd(EN_SET, d); chk("R12 enable after reset", d, 0);
        rd(PD_SET, d); chk("R12 pending after reset", d, 0);
        rd(LVL + 12'h1c, d); chk("R12 level after reset", d, 0);
        chk("R12 req after reset", {31'd0, cpu_req}, 0);
        chk("R12 depth after reset", {29'd0, active_depth}, 0);

        // R1 set-enable walk, then zero write
        exp_en = 0;
        for (int n = 0; n < 32; n += 5) begin
            wr(EN_SET, 32'h1 << n);
            exp_en |= 32'h1 << n;
            rd(EN_SET, d); chk("R1 set-enable walk", d, exp_en);
        end
        wr(EN_SET, 0); rd(EN_CLR, d); chk("R1 zero write no change", d, exp_en);
        // R2 clear-enable
        wr(EN_CLR, 32'h0000_0021); rd(EN_SET, d); chk("R2 clear-enable", d, exp_en & ~32'h21);
        wr(EN_CLR, 0); rd(EN_SET, d); chk("R2 zero write no change", d, exp_en & ~32'h21);
        wr(EN_CLR, 32'hFFFF_FFFF); rd(EN_SET, d); chk("R2 clear all", d, 0);

        // R3 / R4 pending set and clear (all disabled, so no request)
        wr(PD_SET, 32'hA5A5_0F0F); rd(PD_CLR, d); chk("R3 set-pending", d, 32'hA5A5_0F0F);
        chk("R6 disabled lines not offered", {31'd0, cpu_req}, 0);
        wr(PD_CLR, 32'h0505_0003); rd(PD_SET, d); chk("R4 clear-pending", d, 32'hA0A0_0F0C);
        wr(PD_CLR, 32'hFFFF_FFFF); rd(PD_SET, d); chk("R4 clear all", d, 0);

        // R11 level words
        wr(LVL, 32'hFFFF_FFFF); rd(LVL, d); chk("R11 unused bits read zero", d, 32'h0303_0303);
        for (int k = 0; k < 8; k++) begin
            word = 0;
            for (int j = 0; j < 4; j++) word |= 32'(lvl_of(4 * k + j)) << (8 * j);
            wr(LVL + 12'(4 * k), word);
            rd(LVL + 12'(4 * k), d); chk("R11 level word readback", d, word);
        end

        // R6 sweep over all pairs, every sixth line disabled
        en_pat = 0;
        for (int n = 0; n < 32; n++) if (n % 6 != 5) en_pat |= 32'h1 << n;
        wr(EN_SET, en_pat);
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                logic [31:0] elig;
                int best, bl;
                wr(PD_CLR, 32'hFFFF_FFFF);
                wr(PD_SET, (32'h1 << a) | (32'h1 << b));
                elig = ((32'h1 << a) | (32'h1 << b)) & en_pat;
                best = -1; bl = 4;
                for (int i = 0; i < 32; i++)
                    if (elig[i] && lvl_of(i) < bl) begin best = i; bl = lvl_of(i); end
                chk("R6 pair request", {31'd0, cpu_req}, (best >= 0) ? 1 : 0);
                if (best >= 0) chk("R6 pair excnum", {26'd0, cpu_excnum}, 32'(16 + best));
            end
        end

        // Nesting: level of line n becomes n%4
        wr(PD_CLR, 32'hFFFF_FFFF);
        wr(EN_SET, 32'hFFFF_FFFF);
        for (int k = 0; k < 8; k++) wr(LVL + 12'(4 * k), 32'h0302_0100);

        // R5 + R7: hardware line while masked
        @(negedge clk); mask_in = 1'b1; irq_lines = 32'h1 << 7;
        @(negedge clk); irq_lines = 0;
        rd(PD_SET, d); chk("R5 line sets pending", d, 32'h80);
        chk("R7 mask blocks request", {31'd0, cpu_req}, 0);
        @(negedge clk); mask_in = 1'b0;
        #1 chk("R7 unmask delivers", {31'd0, cpu_req}, 1);
        chk("R6 excnum line 7", {26'd0, cpu_excnum}, 23);

        // R4 clear-pending loses to a high line in the same cycle
        @(negedge clk); irq_lines = 32'h1 << 9;
        bus_sel = 1; bus_wr = 1; bus_addr = PD_CLR; bus_wdata = 32'h200;
        @(negedge clk); bus_sel = 0; bus_wr = 0; irq_lines = 0;
        rd(PD_SET, d); chk("R4 line beats clear", d, 32'h280);
        wr(PD_CLR, 32'h200);

        // R9 ack line 7 (level 3)
        pulse_ack();
        chk("R9 depth after ack", {29'd0, active_depth}, 1);
        chk("R9 prio after ack", {30'd0, active_prio}, 3);
        rd(PD_SET, d); chk("R9 pending cleared", d, 0);
        // R8 same level does not preempt
        wr(PD_SET, 32'h1 << 11);
        chk("R8 same level blocked", {31'd0, cpu_req}, 0);
        pulse_ack();
        chk("R9 ack without req ignored", {29'd0, active_depth}, 1);
        rd(PD_SET, d); chk("R9 ignored ack keeps pending", d, 32'h800);
        // deeper nesting
        wr(PD_SET, 32'h1 << 2);
        chk("R8 more urgent preempts", {31'd0, cpu_req}, 1);
        chk("R8 excnum line 2", {26'd0, cpu_excnum}, 18);
        pulse_ack();
        wr(PD_SET, 32'h1 << 1); pulse_ack();
        wr(PD_SET, 32'h1 << 4);
        chk("R8 level 0 preempts level 1", {31'd0, cpu_req}, 1);
        pulse_ack();
        chk("R8 depth four", {29'd0, active_depth}, 4);
        chk("R9 top prio 0", {30'd0, active_prio}, 0);
        chk("R8 nothing beats level 0", {31'd0, cpu_req}, 0);
        // R10 pops
        pulse_ret();
        chk("R10 depth 3", {29'd0, active_depth}, 3);
        chk("R10 prio 1", {30'd0, active_prio}, 1);
        pulse_ret();
        chk("R10 prio 2", {30'd0, active_prio}, 2);
        chk("R8 level 3 blocked under 2", {31'd0, cpu_req}, 0);
        pulse_ret();
        chk("R10 prio 3", {30'd0, active_prio}, 3);
        chk("R8 level 3 blocked under 3", {31'd0, cpu_req}, 0);
        pulse_ret();
        chk("R10 empty depth", {29'd0, active_depth}, 0);
        chk("R10 empty prio reads 0", {30'd0, active_prio}, 0);
        chk("R8 empty stack delivers", {31'd0, cpu_req}, 1);
        chk("R8 excnum line 11", {26'd0, cpu_excnum}, 27);
        pulse_ret();
        chk("R10 ret on empty ignored", {29'd0, active_depth}, 0);

        finish_run();
    end
endmodule